// File: doc/BRIEF.md
# Byte-Wide Floating-Point Accumulator Front End

This block lets an 8-bit processor drive a wide floating-point unit. It holds two 96-bit accumulators, A and B, and places them in a 256-byte window of a 24-bit address space. The processor loads each accumulator one byte at a time, writes a command byte, and then polls a status byte until the operation has finished.

Three commands are handled inside the block, each in a single cycle. SWAP exchanges A and B, NEG flips the sign of A, and ABS clears the sign of A. The six arithmetic and conversion commands go to an external execution port instead. The block presents both accumulators and an operation code with a one-cycle request. It then holds busy until the port signals completion, and writes the returned result into A.

Top module: `fpacc_bytebus`

## Requirements
- R1: `hit` is high only when address bits 23..8 equal bits 23..8 of the window base (default 0xFEA200). A write with `hit` low changes neither accumulator.
- R2: Window offsets 0x00 to 0x0B read and write the bytes of A, least significant byte at 0x00. Offsets 0x10 to 0x1B do the same for B.
- R3: Offset 0x21 reads busy in bit 7 and zeros in bits 6..0. Any other unmapped offset reads 0x00, and `rdata` is 0x00 whenever `hit` is low. After reset both accumulators are zero, busy is 0 and `exe_req` is 0.
- R4: Writing 6 to offset 0x20 (command) exchanges A and B on that clock edge.
- R5: Writing command 7 inverts bit 95 of A and leaves all other bits unchanged.
- R6: Writing command 8 clears bit 95 of A and leaves all other bits unchanged.
- R7: Writing a command from 0 to 5 (0 add, 1 sub, 2 mul, 3 div, 4 int-to-float, 5 float-to-int) sets busy. In the following cycle `exe_req` is high for exactly one cycle, with `exe_op` equal to the code and `exe_a`/`exe_b` equal to A and B.
- R8: While busy, `exe_done` seen after the request cycle loads `exe_res` into A and clears busy on the same edge. B is unchanged.
- R9: While busy, writes to A, B and the command register are ignored. Reads still return the stored values.
- R10: Command codes 9 to 255 change nothing.
- R11: `exe_done` while not busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 24 | Byte address |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data |
| hit | output | 1 | Address falls in the window |
| exe_req | output | 1 | One-cycle request to the execution port |
| exe_op | output | 3 | Operation code for the request |
| exe_a | output | 96 | Accumulator A to the execution port |
| exe_b | output | 96 | Accumulator B to the execution port |
| exe_done | input | 1 | Execution port finished |
| exe_res | input | 96 | Result from the execution port |

## Verification
The hardest window to reach is the busy interval between the request pulse and completion. There, stray writes to accumulator bytes, a second command and a SWAP must all be ignored, while reads must still work. The bench issues a multiply and holds back `exe_done` for several cycles. During that interval it fires these writes and reads back every byte of both accumulators. Only then does it return the result and check that A takes the result while B is unchanged.

// File: rtl/fpacc_bytebus.sv
module fpacc_bytebus #(
  parameter int          W    = 96,
  parameter logic [23:0] BASE = 24'hFEA200
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [23:0]  addr,
  input  logic         wr_en,
  input  logic [7:0]   wdata,
  output logic [7:0]   rdata,
  output logic         hit,
  output logic         exe_req,
  output logic [2:0]   exe_op,
  output logic [W-1:0] exe_a,
  output logic [W-1:0] exe_b,
  input  logic         exe_done,
  input  logic [W-1:0] exe_res
);
  localparam int          NB      = W / 8;
  localparam logic [7:0]  OFF_B   = 8'h10;
  localparam logic [7:0]  OFF_CMD = 8'h20;
  localparam logic [7:0]  OFF_ST  = 8'h21;
  localparam logic [7:0]  C_SWAP  = 8'd6;
  localparam logic [7:0]  C_NEG   = 8'd7;
  localparam logic [7:0]  C_ABS   = 8'd8;

  logic [W-1:0] acc_a, acc_b;
  logic         busy;
  logic [7:0]   off;
  logic         wr_ok, finish;

  assign off    = addr[7:0];
  assign hit    = (addr[23:8] == BASE[23:8]);
  assign wr_ok  = hit && wr_en && !busy;
  assign finish = busy && !exe_req && exe_done;
  assign exe_a  = acc_a;
  assign exe_b  = acc_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_a   <= '0;
      acc_b   <= '0;
      busy    <= 1'b0;
      exe_req <= 1'b0;
      exe_op  <= '0;
    end else begin
      exe_req <= 1'b0;
      if (finish) begin
        acc_a <= exe_res;
        busy  <= 1'b0;
      end
      if (wr_ok) begin
        for (int i = 0; i < NB; i++) begin
          if (off == 8'(i))         acc_a[i*8 +: 8] <= wdata;
          if (off == OFF_B + 8'(i)) acc_b[i*8 +: 8] <= wdata;
        end
        if (off == OFF_CMD) begin
          if (wdata < C_SWAP) begin
            busy    <= 1'b1;
            exe_req <= 1'b1;
            exe_op  <= wdata[2:0];
          end else if (wdata == C_SWAP) begin
            acc_a <= acc_b;
            acc_b <= acc_a;
          end else if (wdata == C_NEG) begin
            acc_a[W-1] <= ~acc_a[W-1];
          end else if (wdata == C_ABS) begin
            acc_a[W-1] <= 1'b0;
          end
        end
      end
    end
  end

  always_comb begin
    rdata = 8'h00;
    if (hit) begin
      for (int i = 0; i < NB; i++) begin
        if (off == 8'(i))         rdata = acc_a[i*8 +: 8];
        if (off == OFF_B + 8'(i)) rdata = acc_b[i*8 +: 8];
      end
      if (off == OFF_ST) rdata = {busy, 7'b0};
    end
  end

  p_req_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    exe_req |-> busy);
  p_req_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    exe_req |=> !exe_req);
  p_done_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !exe_req && exe_done) |=> (!busy && acc_a == $past(exe_res) && $stable(acc_b)));
  p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(exe_done && !exe_req)) |=> ($stable(acc_a) && $stable(acc_b) && busy));
  p_idle_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !wr_en) |=> ($stable(acc_a) && $stable(acc_b) && !busy));
  p_outside_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && !busy) |=> ($stable(acc_a) && $stable(acc_b)));
endmodule

// File: tb/fpacc_bytebus_tb.sv
module fpacc_bytebus_tb;
  localparam logic [23:0] BASE = 24'hFEA200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] addr = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        hit, exe_req, exe_done = 1'b0;
  logic [2:0]  exe_op;
  logic [95:0] exe_a, exe_b, exe_res = '0;
  logic [95:0] ea = '0, eb = '0;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  fpacc_bytebus u_dut (.clk, .rst_n, .addr, .wr_en, .wdata, .rdata, .hit,
    .exe_req, .exe_op, .exe_a, .exe_b, .exe_done, .exe_res);

  task automatic chk(input string req, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [23:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [23:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic rd_acc(input logic [7:0] base, output logic [95:0] v);
    logic [7:0] b;
    for (int i = 0; i < 12; i++) begin
      rd(BASE + {16'h0, base} + 24'(i), b);
      v[i*8 +: 8] = b;
    end
  endtask

  task automatic load(input logic [95:0] a, input logic [95:0] b);
    for (int i = 0; i < 12; i++) begin
      wr(BASE + 24'(i), a[i*8 +: 8]);
      wr(BASE + 24'h10 + 24'(i), b[i*8 +: 8]);
    end
    ea = a; eb = b;
  endtask

  task automatic check_both(input string req);
    logic [95:0] v;
    rd_acc(8'h00, v); chk({req, " A"}, v, ea);
    rd_acc(8'h10, v); chk({req, " B"}, v, eb);
  endtask

  task automatic t_reset;
    logic [7:0] s;
    rd(BASE + 24'h21, s); chk("R3 status", 96'(s), 96'h00);
    chk("R3 req", 96'(exe_req), 96'h0);
    check_both("R3 reset");
  endtask

  task automatic t_map;
    logic [7:0] s;
    load(96'h0123456789ABCDEF_FEDCBA98, 96'hA5A5_5A5A_0F0F_F0F0_1122_3344);
    check_both("R2 map");
    rd(BASE, s); chk("R2 lsb first", 96'(s), 96'h98);
    rd(BASE + 24'h0C, s); chk("R3 unmapped", 96'(s), 96'h00);
  endtask

  task automatic t_decode;
    logic [7:0] s;
    @(negedge clk); addr = 24'hFEA300; #1 chk("R1 hit above", 96'(hit), 96'h0);
    chk("R1 rdata outside", 96'(rdata), 96'h0);
    @(negedge clk); addr = 24'hFEA2FF; #1 chk("R1 hit top", 96'(hit), 96'h1);
    wr(24'hFEA300, 8'hEE);
    wr(24'h7EA210, 8'hEE);
    wr(24'hFEA100, 8'hEE);
    check_both("R1 outside write");
    rd(BASE + 24'h21, s); chk("R1 busy", 96'(s), 96'h0);
  endtask

  task automatic t_internal;
    wr(BASE + 24'h20, 8'd6);
    {ea, eb} = {eb, ea};
    check_both("R4 swap");
    wr(BASE + 24'h20, 8'd7); ea[95] = ~ea[95]; check_both("R5 neg");
    wr(BASE + 24'h20, 8'd7); ea[95] = ~ea[95]; check_both("R5 neg twice");
    ea[95] = 1'b1; wr(BASE + 24'h0B, ea[95:88]);
    wr(BASE + 24'h20, 8'd8); ea[95] = 1'b0; check_both("R6 abs");
    wr(BASE + 24'h20, 8'd8); check_both("R6 abs positive");
  endtask

  task automatic t_undef;
    logic [7:0] s;
    wr(BASE + 24'h20, 8'd9);
    wr(BASE + 24'h20, 8'hFF);
    chk("R10 req", 96'(exe_req), 96'h0);
    rd(BASE + 24'h21, s); chk("R10 busy", 96'(s), 96'h00);
    check_both("R10 undefined");
  endtask

  task automatic t_stray_done;
    @(negedge clk); exe_res = {96{1'b1}}; exe_done = 1'b1;
    @(negedge clk); exe_done = 1'b0;
    check_both("R11 idle done");
  endtask

  task automatic t_external(input logic [7:0] code, input logic [95:0] res);
    logic [7:0] s;
    @(negedge clk); addr = BASE + 24'h20; wdata = code; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    chk("R7 req high", 96'(exe_req), 96'h1);
    chk("R7 op", 96'(exe_op), 96'(code));
    chk("R7 a", exe_a, ea);
    chk("R7 b", exe_b, eb);
    @(negedge clk);
    chk("R7 req pulse", 96'(exe_req), 96'h0);
    rd(BASE + 24'h21, s); chk("R7 busy set", 96'(s), 96'h80);
    wr(BASE + 24'h00, ~ea[7:0]);
    wr(BASE + 24'h1B, ~eb[95:88]);
    wr(BASE + 24'h20, 8'd6);
    wr(BASE + 24'h20, 8'd1);
    chk("R9 no second req", 96'(exe_req), 96'h0);
    check_both("R9 busy");
    rd(BASE + 24'h21, s); chk("R9 still busy", 96'(s), 96'h80);
    @(negedge clk); exe_res = res; exe_done = 1'b1;
    @(negedge clk); exe_done = 1'b0;
    ea = res;
    rd(BASE + 24'h21, s); chk("R8 busy clear", 96'(s), 96'h00);
    check_both("R8 result");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_map;
    t_decode;
    t_internal;
    t_undef;
    t_stray_done;
    t_external(8'd2, 96'h4005_C000_0000_0000_0000_0000);
    t_external(8'd0, 96'h8000_1234_5678_9ABC_DEF0_1357);
    t_external(8'd5, 96'h0000_0000_0000_0000_0000_002A);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule